// File: doc/BRIEF.md
# Serial I/Q Sample Serializer

This block turns parallel I/Q sample pairs into a bit-serial, source-synchronous stream with a framing strobe. It is the kind of line a baseband transmitter drives toward an RF transceiver. The input clock is the bit clock: each rising edge starts one bit period, and the receiver samples the lanes on the same clock. A sample pair enters through a valid/ready handshake. While words are available the block sends them back to back with no gap. When no word is available the lanes and the strobe rest low.

Static configuration inputs select four things: the component width (16 or 12 bits), the strobe style (a single start pulse, or high for the first half of the word), the bit order (MSB or LSB first), and the lane mode. In two-lane mode I and Q shift out side by side. In one-lane mode both components share the I lane, one after the other, and a configuration bit picks which component goes first. The configuration is captured when a word is accepted, so a change applies only from the next word.

Top module: `iqser_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `laneI`, `laneQ` and `strobe` are 0 and `inReady` is 1.
- R2: In two-lane mode (`cfgOneLane`=0) a word lasts W bit periods, where W is 16 when `cfgNarrow`=0 and 12 when `cfgNarrow`=1. `laneI` carries `inI[W-1:0]` and `laneQ` carries `inQ[W-1:0]` in the same bit periods. The order is MSB first when `cfgLsbFirst`=0 and LSB first when `cfgLsbFirst`=1.
- R3: In one-lane mode (`cfgOneLane`=1) a word lasts 2W bit periods on `laneI` and `laneQ` stays 0. I goes first when `cfgQFirst`=0 and Q goes first when `cfgQFirst`=1. Each component uses the bit order of R2.
- R4: A pair is taken at a rising edge where `inValid` and `inReady` are both 1, and its first bit appears in the cycle that follows. `inReady` is 1 when no word is in flight or during the last bit period of the current word, and 0 at every other time.
- R5: When a pair is taken during the last bit period of a word, its first bit follows in the very next bit period, with no idle period between the words.
- R6: After a word ends with no pair taken, `laneI`, `laneQ` and `strobe` are 0 until the next pair is taken.
- R7: With `cfgHalfStrobe`=0 the strobe is 1 in the first bit period of each word and 0 in all of its other bit periods.
- R8: With `cfgHalfStrobe`=1 the strobe is 1 for the first half of the word and 0 for the second half. In two-lane mode that is W/2 periods each. In one-lane mode it is high while the first component is sent and low while the second is sent.
- R9: The configuration inputs are sampled only when a pair is taken. A change in the middle of a word does not alter that word's lanes, strobe or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit period per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgNarrow | input | 1 | 1 selects 12-bit components, 0 selects 16-bit |
| cfgHalfStrobe | input | 1 | 1 selects the half-word strobe, 0 selects the start pulse |
| cfgOneLane | input | 1 | 1 sends I and Q serially on laneI |
| cfgQFirst | input | 1 | In one-lane mode, 1 sends Q before I |
| cfgLsbFirst | input | 1 | 1 sends each component LSB first |
| inValid | input | 1 | Input pair is valid |
| inReady | output | 1 | Block takes the pair at this edge if valid |
| inI | input | 16 | I component; the low 12 bits are used in 12-bit mode |
| inQ | input | 16 | Q component; the low 12 bits are used in 12-bit mode |
| laneI | output | 1 | Serial I lane, or the shared lane in one-lane mode |
| laneQ | output | 1 | Serial Q lane; 0 in one-lane mode |
| strobe | output | 1 | Framing strobe |

## Verification
The embedded properties watch a small set of rules on every cycle: both lanes and the strobe are quiet whenever no word is in flight, the latched configuration stays unchanged inside a word, a pair taken at a word's end restarts the count with no gap, `inReady` drops right after each accepted pair, and the start-pulse strobe stays low after the first bit. The exact bit order on each lane, the choice of first component in one-lane mode, the half-word strobe length and the 12-bit mode can only be shown by the bench. Its reference model replays random and directed mixes of widths, orders and lane modes, and flips the configuration in the middle of words.

// File: rtl/iqser_pkg.sv
`timescale 1ns/1ps
package iqser_pkg;

  typedef struct packed {
    logic narrow;
    logic halfStrobe;
    logic oneLane;
    logic qFirst;
    logic lsbFirst;
  } cfg_t;

  typedef struct packed {
    logic load;     // capture the presented pair
    logic busy;     // a word is on the line
    logic pickQ;    // shared lane currently carries Q
    logic laneBEn;  // second lane in use
  } ctl_t;

endpackage

// File: rtl/iqser_ctrl.sv
`timescale 1ns/1ps
module iqser_ctrl
  import iqser_pkg::*;
#(
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned NARROW_W = 12,
  localparam int unsigned CNT_W   = $clog2(2 * WIDE_W + 1),
  localparam int unsigned IDX_W   = $clog2(WIDE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfgIn,
  input  logic             inValid,
  output logic             inReady,
  output ctl_t             ctl,
  output logic [IDX_W-1:0] bitIdx,
  output logic             strobe
);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  cfg_t             cfgQ;

  logic [CNT_W-1:0] compW;
  logic [CNT_W-1:0] wordLen;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] idxFull;
  logic             lastBit;
  logic             secondHalf;
  logic             load;

  always_comb begin
    compW      = cfgQ.narrow ? CNT_W'(NARROW_W) : CNT_W'(WIDE_W);
    wordLen    = cfgQ.oneLane ? CNT_W'(compW << 1) : compW;
    lastBit    = busy && (bitCnt == wordLen - CNT_W'(1));
    inReady    = !busy || lastBit;
    load       = inValid && inReady;
    secondHalf = cfgQ.oneLane && (bitCnt >= compW);
    pos        = secondHalf ? bitCnt - compW : bitCnt;
    idxFull    = cfgQ.lsbFirst ? pos : compW - CNT_W'(1) - pos;
    bitIdx     = idxFull[IDX_W-1:0];
    if (cfgQ.halfStrobe) strobe = busy && (bitCnt < (wordLen >> 1));
    else                 strobe = busy && (bitCnt == '0);
    ctl.load    = load;
    ctl.busy    = busy;
    ctl.pickQ   = cfgQ.oneLane && (secondHalf ^ cfgQ.qFirst);
    ctl.laneBEn = !cfgQ.oneLane;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
      cfgQ   <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      bitCnt <= '0;
      cfgQ   <= cfgIn;
    end else if (lastBit) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (busy) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  // R9: latched configuration holds for the whole word
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !load) |=> $stable(cfgQ));

  // R5: a pair taken while busy restarts the word with no gap
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (load && busy) |=> (busy && bitCnt == '0));

  // R4: ready drops right after a pair is accepted
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7: start-pulse strobe is quiet after the first bit
  p_short_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgQ.halfStrobe && $past(busy) && !$past(load)) |-> !strobe);

endmodule

// File: rtl/iqser_datapath.sv
`timescale 1ns/1ps
module iqser_datapath
  import iqser_pkg::*;
#(
  parameter int unsigned WIDE_W = 16,
  localparam int unsigned IDX_W = $clog2(WIDE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [WIDE_W-1:0] inI,
  input  logic [WIDE_W-1:0] inQ,
  output logic              laneI,
  output logic              laneQ
);

  logic [WIDE_W-1:0] compReg [2];
  logic [WIDE_W-1:0] compIn  [2];

  assign compIn[0] = inI;
  assign compIn[1] = inQ;

  for (genvar c = 0; c < 2; c++) begin : g_comp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         compReg[c] <= '0;
      else if (ctl.load) compReg[c] <= compIn[c];
    end
  end

  always_comb begin
    laneI = 1'b0;
    laneQ = 1'b0;
    if (ctl.busy) begin
      laneI = ctl.pickQ ? compReg[1][bitIdx] : compReg[0][bitIdx];
      laneQ = ctl.laneBEn && compReg[1][bitIdx];
    end
  end

endmodule

// File: rtl/iqser_top.sv
`timescale 1ns/1ps
module iqser_top
  import iqser_pkg::*;
#(
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned NARROW_W = 12,
  localparam int unsigned IDX_W   = $clog2(WIDE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgNarrow,
  input  logic              cfgHalfStrobe,
  input  logic              cfgOneLane,
  input  logic              cfgQFirst,
  input  logic              cfgLsbFirst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WIDE_W-1:0] inI,
  input  logic [WIDE_W-1:0] inQ,
  output logic              laneI,
  output logic              laneQ,
  output logic              strobe
);

  cfg_t             cfgIn;
  ctl_t             ctl;
  logic [IDX_W-1:0] bitIdx;

  assign cfgIn = '{narrow: cfgNarrow, halfStrobe: cfgHalfStrobe,
                   oneLane: cfgOneLane, qFirst: cfgQFirst, lsbFirst: cfgLsbFirst};

  iqser_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .inValid(inValid),
    .inReady(inReady), .ctl(ctl), .bitIdx(bitIdx), .strobe(strobe)
  );

  iqser_datapath #(.WIDE_W(WIDE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx),
    .inI(inI), .inQ(inQ), .laneI(laneI), .laneQ(laneQ)
  );

  // R6: line is quiet whenever no word is in flight
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |-> (!laneI && !laneQ && !strobe));

  // R3: second lane silent in shared-lane mode
  p_shared_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.laneBEn) |-> !laneQ);

endmodule

// File: tb/iqser_top_tb_top.sv
`timescale 1ns/1ps
module iqser_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cNarrow = 0, cHalf = 0, cOne = 0, cQFirst = 0, cLsb = 0;
  logic        inValid = 0;
  logic [15:0] inI = '0, inQ = '0;
  logic        inReady, laneI, laneQ, strobe;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  iqser_top dut_i (
    .clk(clk), .rstN(rstN), .cfgNarrow(cNarrow), .cfgHalfStrobe(cHalf),
    .cfgOneLane(cOne), .cfgQFirst(cQFirst), .cfgLsbFirst(cLsb),
    .inValid(inValid), .inReady(inReady), .inI(inI), .inQ(inQ),
    .laneI(laneI), .laneQ(laneQ), .strobe(strobe)
  );

  // Reference model state
  logic        mBusy, mB2b;
  int          mCnt;
  logic [15:0] mI, mQ;
  logic [4:0]  mCfg; // {narrow, half, one, qFirst, lsb}

  function automatic int wordLen(input logic [4:0] c);
    int w;
    w = c[4] ? 12 : 16;
    return c[2] ? 2 * w : w;
  endfunction

  function automatic logic expReady();
    return !mBusy || (mCnt == wordLen(mCfg) - 1);
  endfunction

  // returns {strobe, laneI, laneQ}
  function automatic logic [2:0] refBits(input logic [15:0] si, input logic [15:0] sq,
                                         input logic [4:0] c, input int cnt);
    int w, len, pos, idx;
    logic second, a, b, s;
    w      = c[4] ? 12 : 16;
    len    = c[2] ? 2 * w : w;
    second = c[2] && (cnt >= w);
    pos    = second ? cnt - w : cnt;
    idx    = c[0] ? pos : w - 1 - pos;
    if (c[2]) begin
      a = (second ^ c[1]) ? sq[idx] : si[idx];
      b = 1'b0;
    end else begin
      a = si[idx];
      b = sq[idx];
    end
    s = c[3] ? (cnt < len / 2) : (cnt == 0);
    return {s, a, b};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 1'b0; mB2b <= 1'b0; mCnt <= 0; mI <= '0; mQ <= '0; mCfg <= '0;
    end else begin
      mB2b <= inValid && expReady() && mBusy;
      if (inValid && expReady()) begin
        mBusy <= 1'b1; mCnt <= 0; mI <= inI; mQ <= inQ;
        mCfg  <= {cNarrow, cHalf, cOne, cQFirst, cLsb};
      end else if (mBusy) begin
        if (mCnt == wordLen(mCfg) - 1) begin mBusy <= 1'b0; mCnt <= 0; end
        else mCnt <= mCnt + 1;
      end
    end
  end

  task automatic compareNow();
    logic [2:0] e;
    logic cfgDiff;
    string tag;
    e = mBusy ? refBits(mI, mQ, mCfg, mCnt) : 3'b000;
    cfgDiff = mBusy && ({cNarrow, cHalf, cOne, cQFirst, cLsb} != mCfg);
    nChecks++;
    if (inReady !== expReady()) begin
      nFails++;
      $display("FAIL R4: inReady actual %b expected %b", inReady, expReady());
    end
    nChecks++;
    if ({laneI, laneQ} !== e[1:0]) begin
      tag = !mBusy ? "R6" : cfgDiff ? "R9" : mCfg[2] ? "R3" : "R2";
      nFails++;
      $display("FAIL %s: lanes actual %b expected %b (bit %0d)", tag, {laneI, laneQ}, e[1:0], mCnt);
    end
    nChecks++;
    if (strobe !== e[2]) begin
      tag = !mBusy ? "R6" : cfgDiff ? "R9" : (mB2b && mCnt == 0) ? "R5" : mCfg[3] ? "R8" : "R7";
      nFails++;
      $display("FAIL %s: strobe actual %b expected %b (bit %0d)", tag, strobe, e[2], mCnt);
    end
  endtask

  task automatic step(input int validPct, input int cfgPct);
    @(negedge clk);
    compareNow();
    inValid = ($urandom % 100) < validPct;
    inI = 16'($urandom);
    inQ = 16'($urandom);
    if (($urandom % 100) < cfgPct) begin
      {cNarrow, cHalf, cOne, cQFirst, cLsb} = 5'($urandom);
    end
  endtask

  task automatic runPhase(input logic [4:0] c, input int cycles, input int validPct, input int cfgPct);
    {cNarrow, cHalf, cOne, cQFirst, cLsb} = c;
    for (int k = 0; k < cycles; k++) step(validPct, cfgPct);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: quiet line and ready during reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      nChecks++;
      if ({inReady, laneI, laneQ, strobe} !== 4'b1000) begin
        nFails++;
        $display("FAIL R1: {ready,lanes,strobe} actual %b expected 1000",
                 {inReady, laneI, laneQ, strobe});
      end
    end
    rstN = 1'b1;
    // R1: first cycle after reset
    @(negedge clk);
    nChecks++;
    if ({inReady, laneI, laneQ, strobe} !== 4'b1000) begin
      nFails++;
      $display("FAIL R1: after reset actual %b expected 1000", {inReady, laneI, laneQ, strobe});
    end
    // Directed: R2/R7/R5 two-lane 16-bit MSB first, start pulse, back to back
    runPhase(5'b00000, 60, 100, 0);
    // R6: idle after a word
    runPhase(5'b00000, 30, 0, 0);
    // R2/R8: 12-bit, half strobe, LSB first
    runPhase(5'b11001, 50, 100, 0);
    // R3/R8: one lane, Q first, 16-bit, half strobe
    runPhase(5'b01110, 100, 100, 0);
    // R3/R7: one lane, I first, 12-bit, LSB first, start pulse
    runPhase(5'b10101, 80, 100, 0);
    // R9: configuration flipped inside words
    runPhase(5'b00000, 300, 100, 60);
    // Random mix with gaps
    runPhase(5'b00000, 4000, 70, 5);
    runPhase(5'b00000, 40, 0, 0);
    finishRun();
  end

endmodule